// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads descriptors from memory, starting with an entry in a context table and going through up to three levels of page tables. A translation can end at any of the three levels. The level it ends at sets the page size: 16 MB at the first level, 256 KB at the second and 4 KB at the third. A walk that meets an unusable descriptor stops with a fault code. The code gives the level and the kind of problem.

The CPU side sends a virtual address and an access kind. After the walk it gets back the physical address, a page-size code, a fault code, the raw leaf descriptor and a rights field. A separate permission checker uses the leaf descriptor. The rights field only matters when translation is off. Descriptors come through a 32-bit read port with a valid/ready handshake and an error flag.

Three configuration inputs are sampled when a request is accepted:
- an enable bit;
- a boot bit;
- the context table pointer and the context number.

With translation off, addresses pass straight through. If the boot bit is set, instruction fetches go to a boot ROM window instead.

The control is one state machine:
- `S_IDLE` waits for a request. On a request it takes *start_walk* to `S_CTX`, or *bypass* to `S_RESP` when translation is off.
- `S_CTX`, `S_L1`, `S_L2` and `S_L3` each hold one descriptor read. Each leaves on the memory handshake by one of three transitions:
  - *descend* to the next level;
  - *leaf* or *fault* to `S_RESP`;
  - *bus_abort* to `S_RESP` when the memory reports an error.
- `S_RESP` shows the result for one cycle and takes *retire* back to `S_IDLE`.

Top module: `tw_walker`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1 and both `rsp_valid` and `mem_valid` are 0.
- R2: With translation on, the first read of a walk is at address `{cfg_ctp,4'b0} + {cfg_ctx,2'b0}`. This read is the context level, level 0. It uses the values present when the request is accepted.
- R3: The descriptor type is in bits [1:0]: 0 is invalid, 1 is a table pointer, 2 is a page entry, 3 is reserved. A table pointer at levels 0 to 2 leads to the next read at `{desc[31:2],6'b0}` plus an index. The index is `{va[31:24],2'b0}` for level 1, `{va[23:18],2'b0}` for level 2 and `{va[17:12],2'b0}` for level 3.
- R4: A page entry ends the walk with `rsp_fault` = 0, `rsp_rights` = 0 and `rsp_pte` equal to the descriptor. The physical address is `{pte[31:8],12'b0}` plus an offset, which depends on the level:

  | Level | Offset | `rsp_size` |
  |---|---|---|
  | 1 | `va[23:0]` | 2 (16 MB) |
  | 2 | `va[17:0]` | 1 (256 KB) |
  | 3 | `va[11:0]` | 0 (4 KB) |
- R5: An invalid descriptor at level L (0 to 3) ends the walk with `rsp_fault = (L<<8)|(1<<2)`. A reserved descriptor gives `(L<<8)|(4<<2)`. A page entry at level 0 counts as reserved, and so does a table pointer at level 3. A faulting response has `rsp_pa`, `rsp_size`, `rsp_rights` and `rsp_pte` all 0.
- R6: A read that returns with `mem_err` set at level L ends the walk with `rsp_fault = (L<<8)|(7<<2)`. No further read is issued.
- R7: With translation off and no boot redirect, the response appears in the cycle after acceptance. It carries `rsp_pa` = zero-extended VA and `rsp_rights` = 3'b111 (bit 2 read, bit 1 write, bit 0 execute), with fault 0 and size 0. No memory read is made.
- R8: With translation off, the boot bit set and `req_kind` = 2 (instruction fetch), `rsp_pa = PROM_BASE | va[18:0]` and `rsp_rights` = 3'b101. Kinds 0 (load), 1 (store) and 3 follow R7 even with the boot bit set.
- R9: Only one walk is in flight at a time. `req_ready` is 0 from the cycle after acceptance through the response cycle. `rsp_valid` is a one-cycle pulse, and `req_ready` returns to 1 in the next cycle. Requests presented while `req_ready` is 0 are ignored.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid` stays 1 and `mem_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Translation on |
| cfg_boot | input | 1 | Redirect fetches to the boot ROM while translation is off |
| cfg_ctp | input | 32 | Context table pointer (address >> 4) |
| cfg_ctx | input | CTX_W | Context number |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 32 | Virtual address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_pa | output | PA_W | Physical address |
| rsp_size | output | 2 | 0 = 4 KB, 1 = 256 KB, 2 = 16 MB |
| rsp_fault | output | 10 | Level in [9:8], kind in [4:2], 0 = success |
| rsp_rights | output | 3 | Rights for untranslated access (read, write, execute) |
| rsp_pte | output | 32 | Leaf descriptor for the permission checker |
| mem_valid | output | 1 | Descriptor read request |
| mem_ready | input | 1 | Read accepted; data and error valid |
| mem_addr | output | PA_W | Descriptor address |
| mem_rdata | input | 32 | Descriptor word |
| mem_err | input | 1 | Bus error on this read |

## Verification
The directed cases go after the places where levels meet:
- A table pointer at level 3 and a page entry at the context level must fault as reserved. A walker that trusts the type field would keep descending or would return a bogus mapping.
- A bus error in the middle of the walk must stop it at that level. A walker that gets this wrong would issue one more read, which the bench's read count catches, or would report the wrong level.
- The boot case sends a fetch and then a load with the boot bit set. A design that redirected every access kind would send the load into the ROM window.
- Noise requests held during busy cycles would, if accepted, change the result or add an extra response.

Random traffic runs over a hashed memory. It checks the offset width at every leaf level, because a wrong mask changes the page-relative address bits.

// File: rtl/tw_pkg.sv
package tw_pkg;

    localparam int VA_W    = 32;
    localparam int DESC_W  = 32;
    localparam int FLT_W   = 10;
    localparam int L1_LO   = 24;
    localparam int L2_LO   = 18;
    localparam int L3_LO   = 12;
    localparam int PTE_LO  = 8;
    localparam int PTR_LO  = 2;

    typedef enum logic [1:0] {
        LV_CTX = 2'd0,
        LV_1   = 2'd1,
        LV_2   = 2'd2,
        LV_3   = 2'd3
    } walk_lvl_e;

    typedef enum logic [1:0] {
        DT_INVALID = 2'd0,
        DT_TABLE   = 2'd1,
        DT_PAGE    = 2'd2,
        DT_RSVD    = 2'd3
    } desc_type_e;

    typedef enum logic [1:0] {
        PG_4K   = 2'd0,
        PG_256K = 2'd1,
        PG_16M  = 2'd2
    } page_size_e;

    typedef enum logic [1:0] {
        ST_DESCEND = 2'd0,
        ST_LEAF    = 2'd1,
        ST_FAULT   = 2'd2
    } step_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_CTX  = 3'd1,
        S_L1   = 3'd2,
        S_L2   = 3'd3,
        S_L3   = 3'd4,
        S_RESP = 3'd5
    } walk_state_e;

    localparam logic [1:0] ACC_FETCH  = 2'd2;
    localparam logic [2:0] FT_INVALID = 3'd1;
    localparam logic [2:0] FT_RSVD    = 3'd4;
    localparam logic [2:0] FT_BUS     = 3'd7;
    localparam logic [2:0] RT_ALL     = 3'b111;
    localparam logic [2:0] RT_RX      = 3'b101;

    function automatic logic [FLT_W-1:0] mk_fault(walk_lvl_e lvl, logic [2:0] kind);
        return {lvl, 3'b000, kind, 2'b00};
    endfunction

endpackage

// File: rtl/tw_desc_class.sv
module tw_desc_class
    import tw_pkg::*;
(
    input  walk_lvl_e         lvl,
    input  logic [1:0]        dtype,
    output step_e             step,
    output logic [FLT_W-1:0]  fcode
);

    always_comb begin
        step  = ST_FAULT;
        fcode = '0;
        case (desc_type_e'(dtype))
            DT_INVALID: fcode = mk_fault(lvl, FT_INVALID);
            DT_RSVD:    fcode = mk_fault(lvl, FT_RSVD);
            DT_TABLE: begin
                if (lvl == LV_3) fcode = mk_fault(lvl, FT_RSVD);
                else             step  = ST_DESCEND;
            end
            DT_PAGE: begin
                if (lvl == LV_CTX) fcode = mk_fault(lvl, FT_RSVD);
                else               step  = ST_LEAF;
            end
            default:    fcode = mk_fault(lvl, FT_RSVD);
        endcase
    end

endmodule

// File: rtl/tw_next_addr.sv
module tw_next_addr
    import tw_pkg::*;
#(
    parameter int PA_W  = 36,
    parameter int CTX_W = 8
) (
    input  walk_lvl_e                    lvl,
    input  logic [VA_W-1:L3_LO]          va_hi,
    input  logic [DESC_W-1:PTR_LO]       ptr,
    input  logic [31:0]                  ctp,
    input  logic [CTX_W-1:0]             ctx,
    output logic [PA_W-1:0]              root_addr,
    output logic [PA_W-1:0]              next_addr
);

    localparam int IDX_W = VA_W - L1_LO + 2;

    logic [PA_W-1:0]  tbl_base;
    logic [IDX_W-1:0] idx;

    assign root_addr = PA_W'({ctp, 4'b0000}) + PA_W'({ctx, 2'b00});
    assign tbl_base  = PA_W'({ptr, 6'b000000});

    always_comb begin
        case (lvl)
            LV_CTX:  idx = IDX_W'({va_hi[VA_W-1:L1_LO], 2'b00});
            LV_1:    idx = IDX_W'({va_hi[L1_LO-1:L2_LO], 2'b00});
            LV_2:    idx = IDX_W'({va_hi[L2_LO-1:L3_LO], 2'b00});
            default: idx = '0;
        endcase
        next_addr = tbl_base + PA_W'(idx);
    end

endmodule

// File: rtl/tw_leaf_map.sv
module tw_leaf_map
    import tw_pkg::*;
#(
    parameter int PA_W = 36
) (
    input  walk_lvl_e              lvl,
    input  logic [L1_LO-1:0]       va_lo,
    input  logic [DESC_W-1:PTE_LO] pte_addr,
    output logic [PA_W-1:0]        pa,
    output page_size_e             size
);

    logic [PA_W-1:0]  frame;
    logic [L1_LO-1:0] offs;

    assign frame = PA_W'({pte_addr, 12'h000});

    always_comb begin
        case (lvl)
            LV_1: begin
                offs = va_lo;
                size = PG_16M;
            end
            LV_2: begin
                offs = L1_LO'(va_lo[L2_LO-1:0]);
                size = PG_256K;
            end
            default: begin
                offs = L1_LO'(va_lo[L3_LO-1:0]);
                size = PG_4K;
            end
        endcase
        pa = frame + PA_W'(offs);
    end

endmodule

// File: rtl/tw_walker.sv
module tw_walker
    import tw_pkg::*;
#(
    parameter int              PA_W      = 36,
    parameter int              CTX_W     = 8,
    parameter int              ROM_SPAN  = 19,
    parameter logic [PA_W-1:0] PROM_BASE = 36'hF_F000_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_enable,
    input  logic                 cfg_boot,
    input  logic [31:0]          cfg_ctp,
    input  logic [CTX_W-1:0]     cfg_ctx,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [VA_W-1:0]      req_va,
    input  logic [1:0]           req_kind,
    output logic                 rsp_valid,
    output logic [PA_W-1:0]      rsp_pa,
    output logic [1:0]           rsp_size,
    output logic [FLT_W-1:0]     rsp_fault,
    output logic [2:0]           rsp_rights,
    output logic [DESC_W-1:0]    rsp_pte,
    output logic                 mem_valid,
    input  logic                 mem_ready,
    output logic [PA_W-1:0]      mem_addr,
    input  logic [DESC_W-1:0]    mem_rdata,
    input  logic                 mem_err
);

    walk_state_e       state_q, state_d;
    walk_lvl_e         lvl;
    logic              walking;
    logic [VA_W-1:0]   va_q;
    logic [PA_W-1:0]   addr_q;
    logic [PA_W-1:0]   pa_q;
    page_size_e        size_q;
    logic [FLT_W-1:0]  fault_q;
    logic [2:0]        rights_q;
    logic [DESC_W-1:0] pte_q;

    step_e             step;
    logic [FLT_W-1:0]  fcode;
    logic [PA_W-1:0]   root_addr, next_addr, leaf_pa;
    page_size_e        leaf_size;
    logic [PA_W-1:0]   bypass_pa;

    tw_desc_class u_class (
        .lvl   (lvl),
        .dtype (mem_rdata[1:0]),
        .step  (step),
        .fcode (fcode)
    );

    tw_next_addr #(.PA_W(PA_W), .CTX_W(CTX_W)) u_next (
        .lvl       (lvl),
        .va_hi     (va_q[VA_W-1:L3_LO]),
        .ptr       (mem_rdata[DESC_W-1:PTR_LO]),
        .ctp       (cfg_ctp),
        .ctx       (cfg_ctx),
        .root_addr (root_addr),
        .next_addr (next_addr)
    );

    tw_leaf_map #(.PA_W(PA_W)) u_leaf (
        .lvl      (lvl),
        .va_lo    (va_q[L1_LO-1:0]),
        .pte_addr (mem_rdata[DESC_W-1:PTE_LO]),
        .pa       (leaf_pa),
        .size     (leaf_size)
    );

    // Untranslated address: boot ROM window for fetches, identity otherwise
    always_comb begin
        if (cfg_boot && (req_kind == ACC_FETCH))
            bypass_pa = PROM_BASE | PA_W'(req_va[ROM_SPAN-1:0]);
        else
            bypass_pa = PA_W'(req_va);
    end

    always_comb begin
        unique case (state_q)
            S_L1:    lvl = LV_1;
            S_L2:    lvl = LV_2;
            S_L3:    lvl = LV_3;
            default: lvl = LV_CTX;
        endcase
    end

    assign walking = (state_q == S_CTX) || (state_q == S_L1) ||
                     (state_q == S_L2)  || (state_q == S_L3);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) state_d = cfg_enable ? S_CTX : S_RESP;
            end
            S_CTX, S_L1, S_L2, S_L3: begin
                if (mem_ready) begin
                    if (mem_err || (step != ST_DESCEND)) begin
                        state_d = S_RESP;
                    end else begin
                        unique case (state_q)
                            S_CTX:   state_d = S_L1;
                            S_L1:    state_d = S_L2;
                            S_L2:    state_d = S_L3;
                            default: state_d = S_RESP;
                        endcase
                    end
                end
            end
            S_RESP:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Handshake outputs
    always_comb begin
        req_ready = (state_q == S_IDLE);
        rsp_valid = (state_q == S_RESP);
        mem_valid = walking;
    end

    assign mem_addr   = addr_q;
    assign rsp_pa     = pa_q;
    assign rsp_size   = size_q;
    assign rsp_fault  = fault_q;
    assign rsp_rights = rights_q;
    assign rsp_pte    = pte_q;

    // Walk datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q     <= '0;
            addr_q   <= '0;
            pa_q     <= '0;
            size_q   <= PG_4K;
            fault_q  <= '0;
            rights_q <= '0;
            pte_q    <= '0;
        end else if ((state_q == S_IDLE) && req_valid) begin
            va_q     <= req_va;
            addr_q   <= root_addr;
            size_q   <= PG_4K;
            fault_q  <= '0;
            pte_q    <= '0;
            if (cfg_enable) begin
                pa_q     <= '0;
                rights_q <= '0;
            end else begin
                pa_q     <= bypass_pa;
                rights_q <= (cfg_boot && (req_kind == ACC_FETCH)) ? RT_RX : RT_ALL;
            end
        end else if (walking && mem_ready) begin
            if (mem_err) begin
                fault_q <= mk_fault(lvl, FT_BUS);
            end else begin
                unique case (step)
                    ST_DESCEND: addr_q <= next_addr;
                    ST_LEAF: begin
                        pa_q   <= leaf_pa;
                        size_q <= leaf_size;
                        pte_q  <= mem_rdata;
                    end
                    default: fault_q <= fcode;
                endcase
            end
        end
    end

endmodule

// File: rtl/tw_walker_checks.sv
module tw_walker_checks #(
    parameter int PA_W  = 36,
    parameter int CTX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_enable,
    input logic [31:0]      cfg_ctp,
    input logic [CTX_W-1:0] cfg_ctx,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_pa,
    input logic [9:0]       rsp_fault,
    input logic [2:0]       rsp_rights,
    input logic             mem_valid,
    input logic             mem_ready,
    input logic [PA_W-1:0]  mem_addr,
    input logic             mem_err
);

    // R2: first read targets the context entry
    p_root_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cfg_enable) |=>
        (mem_valid && (mem_addr == (PA_W'({$past(cfg_ctp), 4'b0000}) +
                                    PA_W'({$past(cfg_ctx), 2'b00})))));

    // R5: a faulting response carries no address or rights
    p_fault_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault != '0)) |-> ((rsp_pa == '0) && (rsp_rights == 3'b000)));

    // R6: a bus error ends the walk with the bus fault kind
    p_bus_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_err) |=>
        (rsp_valid && !mem_valid && (rsp_fault[4:2] == 3'd7)));

    // R7: untranslated requests answer next cycle without memory traffic
    p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cfg_enable) |=>
        (rsp_valid && !mem_valid && (rsp_fault == '0)));

    // R9: single walk in flight, one-cycle response strobe
    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    p_rsp_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R10: read request held steady until accepted
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));

endmodule

bind tw_walker tw_walker_checks #(.PA_W(PA_W), .CTX_W(CTX_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .cfg_ctp    (cfg_ctp),
    .cfg_ctx    (cfg_ctx),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_pa     (rsp_pa),
    .rsp_fault  (rsp_fault),
    .rsp_rights (rsp_rights),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_err    (mem_err)
);

// File: tb/tw_walker_tb_top.sv
module tw_walker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PA_W       = 36;
    localparam int CTX_W      = 8;
    localparam logic [35:0] ROM_BASE = 36'hF_F000_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b1;
    logic              cfg_enable = 1'b0;
    logic              cfg_boot = 1'b0;
    logic [31:0]       cfg_ctp = '0;
    logic [CTX_W-1:0]  cfg_ctx = '0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [31:0]       req_va = '0;
    logic [1:0]        req_kind = '0;
    logic              rsp_valid;
    logic [PA_W-1:0]   rsp_pa;
    logic [1:0]        rsp_size;
    logic [9:0]        rsp_fault;
    logic [2:0]        rsp_rights;
    logic [31:0]       rsp_pte;
    logic              mem_valid;
    logic              mem_ready = 1'b0;
    logic [PA_W-1:0]   mem_addr;
    logic [31:0]       mem_rdata = '0;
    logic              mem_err = 1'b0;

    int checks = 0;
    int errors = 0;
    int reads  = 0;
    int addr_bad = 0;
    bit done = 0;
    bit err_on = 0;
    logic [35:0] err_addr = '0;
    logic [31:0] mem_tab [logic [35:0]];
    int dly = 0;
    bit prev_wait = 0;
    logic [35:0] prev_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_walker #(.PA_W(PA_W), .CTX_W(CTX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_boot(cfg_boot),
        .cfg_ctp(cfg_ctp), .cfg_ctx(cfg_ctx), .req_valid(req_valid),
        .req_ready(req_ready), .req_va(req_va), .req_kind(req_kind),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_size(rsp_size),
        .rsp_fault(rsp_fault), .rsp_rights(rsp_rights), .rsp_pte(rsp_pte),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_err(mem_err)
    );

    function automatic logic [31:0] rd_word(input logic [35:0] a);
        logic [31:0] h;
        if (mem_tab.exists(a)) return mem_tab[a];
        h = a[31:0] ^ {a[35:32], 28'h0};
        h = h * 32'h9E3779B1;
        h = h ^ (h >> 15);
        h = h * 32'h85EBCA6B;
        h = h ^ (h >> 13);
        return h;
    endfunction

    // Memory responder: random 0..2 cycle wait, answers at the negative edge
    always @(negedge clk) begin
        if (mem_valid && prev_wait && (mem_addr != prev_addr)) addr_bad++;
        prev_wait = mem_valid && !mem_ready;
        prev_addr = mem_addr;
        if (!rst_n || !mem_valid) begin
            mem_ready <= 1'b0;
            dly = $urandom % 3;
        end else if (mem_ready) begin
            mem_ready <= 1'b0;
            prev_wait = 1'b1;
            dly = $urandom % 3;
        end else if (dly == 0) begin
            mem_ready <= 1'b1;
            prev_wait = 1'b0;
            mem_rdata <= rd_word(mem_addr);
            mem_err   <= err_on && (mem_addr == err_addr);
            reads++;
        end else begin
            dly = dly - 1;
        end
    end

    function automatic logic [35:0] root_of(input logic [31:0] ctp, input logic [7:0] ctx);
        return {ctp, 4'b0} + {26'b0, ctx, 2'b0};
    endfunction

    // Reference walk built from the requirements
    function automatic void model(input logic [31:0] va, input logic [1:0] kind,
                                  output logic [35:0] pa, output logic [1:0] sz,
                                  output logic [9:0] flt, output logic [2:0] rt,
                                  output logic [31:0] pte, output int nrd);
        logic [35:0] a;
        logic [31:0] d;
        pa = '0; sz = '0; flt = '0; rt = '0; pte = '0; nrd = 0;
        if (!cfg_enable) begin
            if (cfg_boot && kind == 2'd2) begin
                pa = ROM_BASE | {17'b0, va[18:0]};
                rt = 3'b101;
            end else begin
                pa = {4'b0, va};
                rt = 3'b111;
            end
            return;
        end
        a = root_of(cfg_ctp, cfg_ctx);
        for (int lv = 0; lv < 4; lv++) begin
            nrd++;
            if (err_on && a == err_addr) begin flt = {lv[1:0], 8'h1C}; return; end
            d = rd_word(a);
            case (d[1:0])
                2'd0: begin flt = {lv[1:0], 8'h04}; return; end
                2'd3: begin flt = {lv[1:0], 8'h10}; return; end
                2'd1: begin
                    if (lv == 3) begin flt = {lv[1:0], 8'h10}; return; end
                    if (lv == 0)      a = {d[31:2], 6'b0} + {26'b0, va[31:24], 2'b0};
                    else if (lv == 1) a = {d[31:2], 6'b0} + {28'b0, va[23:18], 2'b0};
                    else              a = {d[31:2], 6'b0} + {28'b0, va[17:12], 2'b0};
                end
                default: begin
                    if (lv == 0) begin flt = {lv[1:0], 8'h10}; return; end
                    if (lv == 1)      pa = {d[31:8], 12'b0} + {12'b0, va[23:0]};
                    else if (lv == 2) pa = {d[31:8], 12'b0} + {18'b0, va[17:0]};
                    else              pa = {d[31:8], 12'b0} + {24'b0, va[11:0]};
                    sz = 2'(3 - lv);
                    pte = d;
                    return;
                end
            endcase
        end
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [31:0] va, input logic [1:0] kind,
                           input bit noise, input string tag);
        logic [35:0] e_pa; logic [1:0] e_sz; logic [9:0] e_f;
        logic [2:0] e_rt; logic [31:0] e_pte; int e_n;
        int rd0, n; bit busy_bad;
        model(va, kind, e_pa, e_sz, e_f, e_rt, e_pte, e_n);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        rd0 = reads;
        req_valid = 1'b1; req_va = va; req_kind = kind;
        @(negedge clk);
        if (cfg_enable) chk({tag, " R2 root address"}, mem_addr, root_of(cfg_ctp, cfg_ctx));
        req_valid = noise;
        if (noise) begin req_va = ~va; req_kind = 2'd1; end
        n = 0; busy_bad = 0;
        while (!rsp_valid && n < 400) begin
            if (req_ready) busy_bad = 1;
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk({tag, " R9 busy ready low"}, {63'b0, busy_bad | req_ready}, 64'd0);
        chk({tag, " R9 response seen"}, {63'b0, rsp_valid}, 64'd1);
        chk({tag, " pa"}, rsp_pa, e_pa);
        chk({tag, " size"}, rsp_size, e_sz);
        chk({tag, " fault"}, rsp_fault, e_f);
        chk({tag, " rights"}, rsp_rights, e_rt);
        chk({tag, " pte"}, rsp_pte, e_pte);
        chk({tag, " read count"}, reads - rd0, e_n);
        @(negedge clk);
        chk({tag, " R9 strobe ends"}, {62'b0, rsp_valid, req_ready}, 64'd1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED_0101));
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset ready", {62'b0, req_ready, rsp_valid}, 64'd2);
        chk("R1 reset mem idle", {63'b0, mem_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", {61'b0, req_ready, rsp_valid, mem_valid}, 64'd4);

        // Directed table: ctx table at 0x1000, context 3
        cfg_enable = 1; cfg_ctp = 32'h100; cfg_ctx = 8'd3;
        mem_tab[36'h100C] = 32'h0000_0201;             // -> L1 table 0x2000
        mem_tab[36'h2048] = 32'h0000_0301;             // va 0x12.. -> L2 table 0x3000
        mem_tab[36'h3034] = 32'h0000_0401;             // -> L3 table 0x4000
        mem_tab[36'h4014] = 32'hABCD_E01A;             // 4 KB page
        run_one(32'h1234_5678, 2'd0, 0, "R3 R4 level3 leaf");
        mem_tab[36'h2000 + {26'b0, 8'h55, 2'b0}] = 32'h7654_3212;
        run_one(32'h55AB_CDEF, 2'd1, 0, "R4 level1 16MB");
        mem_tab[36'h2000 + {26'b0, 8'h66, 2'b0}] = 32'h0000_0301;
        mem_tab[36'h3000 + {28'b0, 6'h2A, 2'b0}] = 32'h1357_9BDE;
        run_one(32'h66AB_FFFF, 2'd2, 1, "R4 R9 level2 256KB with noise");
        mem_tab[36'h4014] = 32'h0000_0501;
        run_one(32'h1234_5678, 2'd0, 0, "R5 level3 table reserved");
        mem_tab[36'h2048] = 32'h0000_0000;
        run_one(32'h1234_5678, 2'd0, 0, "R5 level1 invalid");
        mem_tab[36'h2048] = 32'h0000_0303;
        run_one(32'h1234_5678, 2'd0, 0, "R5 level1 reserved");
        mem_tab[36'h2048] = 32'h0000_0301;
        cfg_ctx = 8'd5; mem_tab[36'h1014] = 32'h0;
        run_one(32'h1234_5678, 2'd0, 0, "R5 context invalid");
        mem_tab[36'h1014] = 32'hFFFF_FF02;
        run_one(32'h1234_5678, 2'd0, 0, "R5 context page reserved");
        cfg_ctx = 8'd3; mem_tab[36'h4014] = 32'hABCD_E01A;
        err_on = 1; err_addr = 36'h3034;
        run_one(32'h1234_5678, 2'd1, 0, "R6 bus error level2");
        err_addr = 36'h100C;
        run_one(32'h1234_5678, 2'd1, 0, "R6 bus error context");
        err_on = 0;

        cfg_enable = 0; cfg_boot = 0;
        run_one(32'hDEAD_BEEF, 2'd1, 0, "R7 passthrough store");
        run_one(32'h8000_1234, 2'd2, 1, "R7 passthrough fetch");
        cfg_boot = 1;
        run_one(32'hCAFE_F00D, 2'd2, 0, "R8 boot fetch rom");
        run_one(32'hCAFE_F00D, 2'd0, 0, "R8 boot load passthrough");
        run_one(32'h0007_FFFF, 2'd3, 0, "R8 boot kind3 passthrough");

        for (int i = 0; i < 300; i++) begin
            cfg_enable = ($urandom % 8) != 0;
            cfg_boot   = $urandom % 2;
            case ($urandom % 3)
                0: cfg_ctp = 32'h100;
                1: cfg_ctp = 32'h0040_0000;
                default: cfg_ctp = $urandom;
            endcase
            cfg_ctx = 8'($urandom);
            err_on = ($urandom % 6) == 0;
            err_addr = (($urandom % 2) == 0) ? root_of(cfg_ctp, cfg_ctx) : 36'h2048;
            run_one($urandom, 2'($urandom), ($urandom % 4) == 0, "R3 R4 R5 R6 R7 R8 random");
        end
        err_on = 0;
        chk("R10 address held while waiting", addr_bad, 0);
        finish_run();
    end

endmodule